// File: doc/BRIEF.md
# Manchester Line Repeater with Sync-Gated Serial Reset

This block sits on a serial Manchester link, runs from a clock at OVS times the bit rate (OVS = 16 by default, a power of two of at least 16), and does two things. It repeats the incoming line signal onto a pair of complementary outputs, retimed to that clock and delayed by half a bit, together with a 2X clock from a phase counter that locks to the received bit timing. It also decodes the line and produces NRZ data, a 1X decode clock and a valid flag.

Two outputs come from what the decoder finds on the line. A sync-type output shows whether the most recent sync pulse was a command sync or a data sync. A serial reset output for downstream logic falls when the block is reset and stays low after that. It rises only when a sync pulse and two valid bits arrive and the first of those bits, the reset bit, is zero.

Line encoding: a bit of value 1 is high for the first half of its cell and low for the second half, and a 0 is the reverse. A command sync is high for 1.5 bit periods and then low for 1.5 bit periods. A data sync is the same shape with the levels swapped. The first data cell begins right after the sync.

Top module: `mch_repeater`

## Requirements
- R1: While `send_hold` is low, `rep_pos` equals the `line_in` value captured OVS/2+1 clock edges earlier (0.5 to 1 bit period), and `rep_neg` is its complement.
- R2: While `send_hold` is low, `clk2x_out` is a square wave with a period of OVS/2 cycles (two periods per bit), derived from the decoder's bit phase.
- R3: `send_hold` high at a clock edge forces `rep_pos` = 1, `rep_neg` = 1 and `clk2x_out` = 0 after that edge; changes of `send_hold` produce no other line activity and do not disturb decoding.
- R4: `sync_is_cmd` is 1 after a command sync and 0 after a data sync, holds its value until the next sync pulse, and is 0 after reset.
- R5: With `rst_n` low at a clock edge, `link_rst_n`, `dec_ok`, `dec_clk` and `dec_data` are 0 after that edge, and `link_rst_n` remains 0 after `rst_n` returns high until a release under R6.
- R6: `link_rst_n` rises only after a sync followed by two valid bits whose first bit (the reset bit) is 0, and then stays high until `rst_n` goes low.
- R7: If the reset bit is 1, `link_rst_n` stays low and the block waits for the next sync pulse.
- R8: `dec_data` presents decoded bits in line order, stable at each falling edge of `dec_clk`; `dec_ok` rises with the second valid bit after a sync, so the bits marked valid are the second and later bits of the frame.
- R9: A cell with no mid-cell transition drops `dec_ok` to 0, and decoding stays stopped until the next sync; if this happens in the first or second cell, no release takes place.
- R10: Sync halves within ±OVS/8 cycles of 1.5 bits are accepted, and every mid-cell transition realigns the bit phase, so half-cells that vary by ±1 cycle still decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| send_hold | input | 1 | High: line outputs idle high and 2X clock held low |
| line_in | input | 1 | Unipolar Manchester input |
| rep_pos | output | 1 | Repeated line data |
| rep_neg | output | 1 | Complement of repeated line data |
| clk2x_out | output | 1 | Recovered 2X bit-rate clock |
| sync_is_cmd | output | 1 | 1 = last sync was a command sync, 0 = data sync |
| link_rst_n | output | 1 | Serial reset output, released by a sync with reset bit 0 |
| dec_data | output | 1 | Decoded NRZ data |
| dec_clk | output | 1 | 1X decode clock; data is stable at its falling edge |
| dec_ok | output | 1 | Decoded data valid |

## Verification
The assertions assume that `line_in` is synchronous to `clk` and that each half-cell lasts OVS/2 cycles, give or take at most one cycle. They also assume that every sync pulse is preceded by idle at the opposite level for longer than 1.5 bits, so the first half of the sync has a clean start. The stimulus drives the line on the falling clock edge and draws each half-cell length from {H-1, H, H+1}. It puts four bit periods of opposite-level idle before every sync. An invalid cell is formed only by holding one level for a whole cell, so the run lengths stay inside the windows the decoder expects.

// File: rtl/mrep_pkg.sv
// Shared types and helpers for the Manchester repeater.
// Assumes: nothing beyond IEEE 1800-2017.
package mrep_pkg;

    // Decoder phases: look for a sync start, confirm its second half, decode cells.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_DATA  = 2'd2
    } dec_state_t;

    // True when val lies within +/- tol of centre.
    function automatic logic in_window(input int val, input int centre, input int tol);
        return (val >= centre - tol) && (val <= centre + tol);
    endfunction

endpackage

// File: rtl/mrep_sampler.sv
// Input capture and run-length measurement.
// Registers the line input once, flags a level change and counts how many
// samples the previous level lasted (saturating).
// Assumes: line_in is synchronous to clk.
module mrep_sampler #(
    parameter int OVS = 16,
    parameter int RLW = $clog2(4 * OVS) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_in,
    output logic           smp,
    output logic           edge_seen,
    output logic [RLW-1:0] run_len
);
    localparam logic [RLW-1:0] RUN_MAX = '1;
    localparam logic [RLW-1:0] RUN_ONE = RLW'(1);

    logic cur_q, old_q;
    logic [RLW-1:0] run_q;

    // Capture the line, keep the previous sample, count samples since the last change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            old_q <= 1'b0;
            run_q <= '0;
        end else begin
            cur_q <= line_in;
            old_q <= cur_q;
            if (cur_q != old_q)
                run_q <= RUN_ONE;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    assign smp       = cur_q;
    assign edge_seen = cur_q ^ old_q;
    assign run_len   = run_q;

endmodule

// File: rtl/mrep_decoder.sv
// Sync detection and Manchester cell decoding with a free-running bit phase.
// HUNT looks for a 1.5-bit run followed by an edge; SYNC2 checks that the
// second half stays quiet long enough and places the first cell 1.5 bits after
// the sync's middle edge; DATA samples each half-cell at its quarter points and
// realigns the phase on mid-cell edges.
// Assumes: OVS is a power of two, at least 16.
module mrep_decoder
    import mrep_pkg::*;
#(
    parameter int OVS = 16,
    parameter int RLW = $clog2(4 * OVS) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp,
    input  logic           edge_seen,
    input  logic [RLW-1:0] run_len,
    output logic           dec_data,
    output logic           dec_clk,
    output logic           dec_ok,
    output logic           clk2x_raw,
    output logic           sync_done,
    output logic           sync_kind,
    output logic           pair_ok,
    output logic           first_bit
);
    localparam int CW       = $clog2(OVS);
    localparam int H        = OVS / 2;
    localparam int Q        = OVS / 4;
    localparam int TOL      = OVS / 8;
    localparam int SYNC_LEN = 3 * H;
    localparam int SCW      = $clog2(SYNC_LEN + 1);

    localparam logic [CW-1:0]  PH_Q1    = CW'(Q);
    localparam logic [CW-1:0]  PH_Q3    = CW'(H + Q);
    localparam logic [CW-1:0]  PH_LAST  = CW'(OVS - 1);
    localparam logic [CW-1:0]  PH_HALF  = CW'(H);
    localparam logic [CW-1:0]  PH_MIDP  = CW'(H + 1);
    localparam logic [SCW-1:0] CNT_END  = SCW'(SYNC_LEN - 1);
    localparam logic [SCW-1:0] CNT_MIN  = SCW'(SYNC_LEN - TOL);
    localparam logic [SCW-1:0] CNT_ONE  = SCW'(1);

    dec_state_t     state;
    logic [CW-1:0]  ph;
    logic [SCW-1:0] cnt;
    logic           lvl_q;
    logic           half_a, half_b;
    logic [1:0]     bcnt;
    logic           rbit_q;
    logic           data_q, ok_q, dclk_q;
    logic           done_q, pair_q;

    logic sync_run, mid_win, cell_end, cell_good;

    // Classify the measured run, the phase window and the cell result.
    always_comb begin
        sync_run  = in_window(int'(run_len), SYNC_LEN, TOL);
        mid_win   = in_window(int'(ph), H, TOL);
        cell_end  = (state == ST_DATA) && (ph == PH_LAST);
        cell_good = half_a != half_b;
    end

    // Sequence hunt, sync confirmation and cell decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            ph     <= '0;
            cnt    <= '0;
            lvl_q  <= 1'b0;
            half_a <= 1'b0;
            half_b <= 1'b0;
            bcnt   <= 2'd0;
            rbit_q <= 1'b0;
            data_q <= 1'b0;
            ok_q   <= 1'b0;
            done_q <= 1'b0;
            pair_q <= 1'b0;
        end else begin
            ph     <= ph + 1'b1;
            done_q <= 1'b0;
            pair_q <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (edge_seen && sync_run) begin
                        state <= ST_SYNC2;
                        lvl_q <= ~smp;
                        cnt   <= CNT_ONE;
                    end
                end
                ST_SYNC2: begin
                    if (edge_seen && (cnt < CNT_MIN)) begin
                        state <= ST_HUNT;
                    end else if (cnt == CNT_END) begin
                        state  <= ST_DATA;
                        ph     <= '0;
                        bcnt   <= 2'd0;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (edge_seen && mid_win)
                        ph <= PH_MIDP;
                    if (ph == PH_Q1)
                        half_a <= smp;
                    if (ph == PH_Q3)
                        half_b <= smp;
                    if (cell_end) begin
                        if (cell_good) begin
                            data_q <= half_a;
                            if (bcnt == 2'd0)
                                rbit_q <= half_a;
                            if (bcnt == 2'd1) begin
                                ok_q   <= 1'b1;
                                pair_q <= 1'b1;
                            end
                            if (bcnt != 2'd2)
                                bcnt <= bcnt + 1'b1;
                        end else begin
                            ok_q  <= 1'b0;
                            state <= ST_HUNT;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // 1X decode clock: high over the first half of each phase cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dclk_q <= 1'b0;
        else
            dclk_q <= (ph < PH_HALF);
    end

    assign dec_data  = data_q;
    assign dec_ok    = ok_q;
    assign dec_clk   = dclk_q;
    assign clk2x_raw = ~ph[CW-2];
    assign sync_done = done_q;
    assign sync_kind = lvl_q;
    assign pair_ok   = pair_q;
    assign first_bit = rbit_q;

    AST_SYNC_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> $past(state == ST_SYNC2)); // R4
    AST_OK_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_ok) |-> $past(state == ST_DATA) && pair_ok); // R8
    AST_BAD_CELL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_end && !cell_good) |=> !dec_ok && state == ST_HUNT); // R9

endmodule

// File: rtl/mrep_line_out.sv
// Repeated line outputs and recovered 2X clock.
// Delays the captured input by a chain of OVS/2-1 stages plus an output
// register, and forces the outputs idle while hold is high.
// Assumes: smp is the once-registered line sample.
module mrep_line_out #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic smp,
    input  logic clk2x_raw,
    output logic rep_pos,
    output logic rep_neg,
    output logic clk2x_out
);
    localparam int DLY = OVS / 2 - 1;

    logic tap [DLY];

    for (genvar i = 0; i < DLY; i++) begin : g_stage
        if (i == 0) begin : g_head
            // First delay stage takes the captured line sample.
            always_ff @(posedge clk) begin
                if (!rst_n) tap[0] <= 1'b0;
                else        tap[0] <= smp;
            end
        end else begin : g_body
            // Later delay stages shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) tap[i] <= 1'b0;
                else        tap[i] <= tap[i-1];
            end
        end
    end

    // Output register: idle-high pair and quiet clock under hold, else repeat.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            rep_pos   <= 1'b1;
            rep_neg   <= 1'b1;
            clk2x_out <= 1'b0;
        end else begin
            rep_pos   <= tap[DLY-1];
            rep_neg   <= ~tap[DLY-1];
            clk2x_out <= clk2x_raw;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> rep_pos && rep_neg && !clk2x_out); // R3
    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> rep_neg == !rep_pos); // R1

endmodule

// File: rtl/mrep_link_gate.sv
// Sync-type flag and sync-gated serial reset.
// The serial reset falls with the block reset and is released only by a
// confirmed bit pair whose first bit is zero.
// Assumes: sync_done and pair_ok are single-cycle pulses.
module mrep_link_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_done,
    input  logic sync_kind,
    input  logic pair_ok,
    input  logic first_bit,
    output logic link_rst_n,
    output logic sync_is_cmd
);
    // Record the last sync type and latch the serial reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_rst_n  <= 1'b0;
            sync_is_cmd <= 1'b0;
        end else begin
            if (sync_done)
                sync_is_cmd <= sync_kind;
            if (pair_ok && !first_bit)
                link_rst_n <= 1'b1;
        end
    end

    AST_KIND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_done |=> $stable(sync_is_cmd)); // R4
    AST_RELEASE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_rst_n) |-> $past(pair_ok) && !$past(first_bit)); // R6
    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst_n |=> link_rst_n); // R6
    AST_ONE_BIT_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ok && first_bit && !link_rst_n) |=> !link_rst_n); // R7

endmodule

// File: rtl/mch_repeater.sv
// Manchester line repeater with sync-gated serial reset (top level).
// Connects input capture, decoder, line output stage and reset gate.
// Assumes: one clock at OVS x bit rate; OVS a power of two, at least 16.
module mch_repeater #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send_hold,
    input  logic line_in,
    output logic rep_pos,
    output logic rep_neg,
    output logic clk2x_out,
    output logic sync_is_cmd,
    output logic link_rst_n,
    output logic dec_data,
    output logic dec_clk,
    output logic dec_ok
);
    localparam int RLW = $clog2(4 * OVS) + 1;

    logic           smp, edge_seen;
    logic [RLW-1:0] run_len;
    logic           clk2x_raw, sync_done, sync_kind, pair_ok, first_bit;

    mrep_sampler #(.OVS(OVS), .RLW(RLW)) u_smp (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .smp(smp), .edge_seen(edge_seen), .run_len(run_len)
    );

    mrep_decoder #(.OVS(OVS), .RLW(RLW)) u_dec (
        .clk(clk), .rst_n(rst_n), .smp(smp), .edge_seen(edge_seen), .run_len(run_len),
        .dec_data(dec_data), .dec_clk(dec_clk), .dec_ok(dec_ok), .clk2x_raw(clk2x_raw),
        .sync_done(sync_done), .sync_kind(sync_kind), .pair_ok(pair_ok), .first_bit(first_bit)
    );

    mrep_line_out #(.OVS(OVS)) u_out (
        .clk(clk), .rst_n(rst_n), .hold(send_hold), .smp(smp), .clk2x_raw(clk2x_raw),
        .rep_pos(rep_pos), .rep_neg(rep_neg), .clk2x_out(clk2x_out)
    );

    mrep_link_gate u_gate (
        .clk(clk), .rst_n(rst_n), .sync_done(sync_done), .sync_kind(sync_kind),
        .pair_ok(pair_ok), .first_bit(first_bit),
        .link_rst_n(link_rst_n), .sync_is_cmd(sync_is_cmd)
    );

endmodule

// File: tb/sim_mch_repeater.sv
module sim_mch_repeater;
    localparam int OVS = 16;
    localparam int H   = OVS / 2;

    logic clk = 1'b0, rst_n = 1'b0, send_hold = 1'b0, line_in = 1'b0;
    logic rep_pos, rep_neg, clk2x_out, sync_is_cmd, link_rst_n, dec_data, dec_clk, dec_ok;

    mch_repeater #(.OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .send_hold(send_hold), .line_in(line_in),
        .rep_pos(rep_pos), .rep_neg(rep_neg), .clk2x_out(clk2x_out),
        .sync_is_cmd(sync_is_cmd), .link_rst_n(link_rst_n),
        .dec_data(dec_data), .dec_clk(dec_clk), .dec_ok(dec_ok)
    );

    always #2 clk = ~clk;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  done = 0, mon_en = 0;
    logic hist [256];
    logic holdh [256];
    int  rep_err = 0, hold_err = 0, hold_seen = 0;
    logic prev_dclk = 1'b0;
    int  cap_n = 0;
    logic cap [64];
    logic fbits [16];
    bit  link_exp = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Record input and hold as captured at each edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        hist[cyc % 256]  = line_in;
        holdh[cyc % 256] = send_hold;
    end

    // Repeater monitor: outputs vs delayed input (R1) or idle under hold (R3).
    always @(negedge clk) begin
        if (mon_en) begin
            if (holdh[cyc % 256]) begin
                hold_seen++;
                if (!(rep_pos && rep_neg && !clk2x_out)) hold_err++;
            end else if (rep_pos !== hist[(cyc - H) % 256] || rep_neg !== ~hist[(cyc - H) % 256]) begin
                rep_err++;
            end
        end
    end

    // Capture valid decoded bits at falling decode clock (R8).
    always @(negedge clk) begin
        if (prev_dclk && !dec_clk && dec_ok && cap_n < 64) begin
            cap[cap_n] = dec_data;
            cap_n++;
        end
        prev_dclk = dec_clk;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic drive(input logic lvl, input int dur);
        repeat (dur) begin
            @(negedge clk);
            line_in = lvl;
        end
    endtask

    function automatic int jj(input bit en);
        if (!en) return 0;
        return int'($urandom_range(2, 0)) - 1;
    endfunction

    task automatic send_frame(input bit is_cmd, input int n, input bit jit, input int bad);
        logic v;
        v = is_cmd;
        cap_n = 0;
        drive(~v, 4 * OVS);
        drive(v, 3 * H + jj(jit));
        drive(~v, 3 * H + jj(jit));
        for (int i = 0; i < n; i++) begin
            if (i == bad) begin
                drive(fbits[i], 2 * H);
            end else begin
                drive(fbits[i], H + jj(jit));
                drive(~fbits[i], H + jj(jit));
            end
        end
        drive(line_in, 4 * OVS);
    endtask

    task automatic check_frame(input bit is_cmd, input int n, input int bad, input string tag);
        int vc, expn, mism;
        vc = (bad < 0) ? n : bad;
        if (vc >= 2 && fbits[0] == 1'b0) link_exp = 1;
        expn = (vc >= 2) ? vc - 1 : 0;
        chk(sync_is_cmd == is_cmd, {"R4 sync type ", tag}, sync_is_cmd, is_cmd);
        chk(link_rst_n == link_exp, {"R6/R7 serial reset ", tag}, link_rst_n, link_exp);
        mism = 0;
        for (int i = 0; i < expn && i < cap_n; i++)
            if (cap[i] !== fbits[i + 1]) mism++;
        chk(cap_n == expn && mism == 0, {"R8 decoded bits ", tag}, cap_n * 100 + mism, expn * 100);
        chk(dec_ok == 1'b0, {"R9 valid low after frame ", tag}, dec_ok, 0);
    endtask

    task automatic count_rises(input int ncyc, output int rises);
        logic p;
        rises = 0;
        @(negedge clk);
        p = clk2x_out;
        repeat (ncyc) begin
            @(negedge clk);
            if (!p && clk2x_out) rises++;
            p = clk2x_out;
        end
    endtask

    task automatic load(input logic [15:0] pat, input int n);
        for (int i = 0; i < n; i++) fbits[i] = pat[n - 1 - i];
    endtask

    initial begin
        int r;
        void'($urandom(32'h5eed));
        // R5: reset state
        repeat (3) @(negedge clk);
        chk(link_rst_n == 0, "R5 link low in reset", link_rst_n, 0);
        chk(dec_ok == 0 && dec_clk == 0 && dec_data == 0, "R5 decoder outputs low in reset",
            {dec_ok, dec_clk, dec_data}, 0);
        chk(sync_is_cmd == 0, "R4 sync type after reset", sync_is_cmd, 0);
        rst_n = 1;
        repeat (20) @(negedge clk);
        mon_en = 1;

        // R2: 2X clock on idle line
        count_rises(4 * OVS, r);
        chk(r == 8, "R2 clk2x rises per 4 bits", r, 8);

        // R7: command sync, reset bit 1
        load(16'b10110, 5);
        send_frame(1, 5, 0, -1);
        check_frame(1, 5, -1, "R7 cmd rbit1");
        // R4/R7: data sync, reset bit 1
        load(16'b1001101, 7);
        send_frame(0, 7, 0, -1);
        check_frame(0, 7, -1, "R7 data rbit1");
        // R9: reset bit 0 but second cell invalid
        load(16'b0011, 4);
        send_frame(1, 4, 0, 1);
        check_frame(1, 4, 1, "R9 bad second cell");
        // R6: data sync, reset bit 0
        load(16'b0101100, 7);
        send_frame(0, 7, 0, -1);
        check_frame(0, 7, -1, "R6 release");
        // R9: invalid cell mid-frame
        load(16'b11010011, 8);
        send_frame(1, 8, 0, 4);
        check_frame(1, 8, 4, "R9 mid-frame bad cell");

        // R3: hold toggles while a frame is repeated and decoded
        load(16'b1100101, 7);
        fork
            send_frame(0, 7, 0, -1);
            begin
                repeat (6) begin
                    repeat (37) @(negedge clk);
                    send_hold = ~send_hold;
                end
            end
        join
        check_frame(0, 7, -1, "R3 hold toggling");
        chk(hold_seen > 0 && hold_err == 0, "R3 idle outputs under hold", hold_err, 0);
        send_hold = 1;
        count_rises(4 * OVS, r);
        chk(r == 0, "R3 clk2x quiet under hold", r, 0);
        send_hold = 0;
        chk(rep_err == 0, "R1 repeat delay and complement", rep_err, 0);

        // R5: reset after release, serial reset stays low afterwards
        mon_en = 0;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(link_rst_n == 0 && dec_ok == 0 && dec_clk == 0, "R5 outputs low on reset",
            {link_rst_n, dec_ok, dec_clk}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        link_exp = 0;
        drive(line_in, 200);
        chk(link_rst_n == 0, "R5 link stays low after reset", link_rst_n, 0);
        mon_en = 1;

        // R10: random frames with +/-1 cycle half-cell jitter
        for (int k = 0; k < 16; k++) begin
            bit c;
            int n, bad;
            c = 1'($urandom % 2);
            n = 3 + int'($urandom % 8);
            for (int i = 0; i < n; i++) fbits[i] = 1'($urandom % 2);
            bad = ($urandom % 4 == 0) ? int'($urandom % n) : -1;
            send_frame(c, n, 1, bad);
            check_frame(c, n, bad, "R10 jitter random");
        end
        chk(rep_err == 0, "R1 repeat under jitter", rep_err, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule